// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Unit

This block is the front end of an instruction fetch path. It takes one fetch address at a time, together with a flag that says whether 16-bit compressed instructions are legal. It returns a 32-bit instruction word with a one-cycle valid pulse. Most fetches are served by a small direct-mapped instruction cache. On a hit the word comes back one cycle after the request without touching memory. On a miss the word is read from memory and written into the cache.

When compressed mode is on and the fetch address sits two bytes into a word, the instruction may straddle a word boundary. In that case the cache is bypassed and the instruction is assembled from halfword reads. The low halfword is read first. Only when its two low bits are both 1, which marks a full-width encoding, is the following halfword read and placed in the upper half of the result.

A flush input invalidates every cache entry in one cycle. The memory port is a simple request/acknowledge handshake that carries an address and a halfword/word size flag.

Top module: `ifetch_unit`

## Requirements
- R1: With `req_cmode`=1 and `req_addr[1:0]`=2'b10, the first memory request after acceptance is a halfword read (`mem_half`=1) at `req_addr`, issued in the cycle after acceptance.
- R2: On that boundary path, if the low halfword has bits [1:0]=2'b11, a second halfword read at `req_addr`+2 follows in its own handshake, and the result is {second halfword, first halfword}.
- R3: On that boundary path, if the low halfword has bits [1:0]≠2'b11, no second read is made and the result is {16'h0000, first halfword}.
- R4: All other fetches look up a direct-mapped cache indexed by `req_addr[IDX_W+1:2]`. On a valid hit, `inst_valid` rises in the cycle after acceptance with the stored word, and no memory request is made.
- R5: On a cache miss, one word read (`mem_half`=0) is made at the full fetch address. The returned data is delivered as the result in the cycle after `mem_ack`, and it overwrites the tag and data of that cache entry.
- R6: The cache tag is the full fetch address, so two addresses that share an index but differ elsewhere miss against each other and evict each other.
- R7: A boundary-path fetch neither reads nor writes the cache. It always goes to memory, and it leaves existing entries hitting.
- R8: `flush` clears every valid bit at the next clock edge and takes priority over a fill at that same edge. The next fetch of a flushed address misses.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr` and `mem_half` hold their values.
- R10: After reset `req_ready`=1, `mem_req`=0 and `inst_valid`=0, and every cache entry is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Fetch request strobe |
| req_addr | input | AW | Fetch byte address |
| req_cmode | input | 1 | Compressed instructions allowed |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| flush | input | 1 | Invalidate the whole cache |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read byte address |
| mem_half | output | 1 | 1 = halfword read in [15:0], 0 = word read |
| mem_ack | input | 1 | Read data valid, request complete |
| mem_rdata | input | 32 | Read data |
| inst_valid | output | 1 | Result strobe, one cycle |
| inst_word | output | 32 | Fetched instruction word |

## Verification
The fetch is tried with the following patterns, chosen to tell the two paths and the tag rule apart:
- Aligned addresses, first cold and then repeated, which separates a miss from a hit by the number of memory reads seen.
- Two aligned addresses that share an index, which proves the whole address is compared.
- A misaligned address with compressed mode off, which must use the cache even though the same address with compressed mode on must not.
- Boundary addresses whose first halfword is and is not compressed, which separates the one-read and two-read assemblies and checks where each halfword lands.
- A flush between fetches, and a flush that lands on the same edge as a fill, which show that flush wins.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int ILEN = 32;
    localparam int HLEN = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WORD,
        ST_LO,
        ST_HI
    } fetch_st_e;

    // a halfword is a short encoding unless both low bits are set
    function automatic logic is_short(input logic [HLEN-1:0] h);
        return h[1:0] != 2'b11;
    endfunction

endpackage

// File: rtl/ifu_icache.sv
module ifu_icache #(
    parameter int AW    = 32,
    parameter int IDX_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [AW-1:0]          rd_addr,
    output logic                   rd_hit,
    output logic [ifu_pkg::ILEN-1:0] rd_data,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [ifu_pkg::ILEN-1:0] wr_data
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [AW-1:0]            tag_mem  [ENTRIES];
    logic [ifu_pkg::ILEN-1:0] data_mem [ENTRIES];
    logic [ENTRIES-1:0]       valid_d, valid_q;
    logic [IDX_W-1:0]         rd_idx, wr_idx;

    assign rd_idx = rd_addr[IDX_W+1:2];
    assign wr_idx = wr_addr[IDX_W+1:2];

    assign rd_hit  = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_addr);
    assign rd_data = data_mem[rd_idx];

    always_comb begin
        valid_d = valid_q;
        if (flush) begin
            valid_d = '0;
        end else if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_addr;
            data_mem[wr_idx] <= wr_data;
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R8

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> valid_q[$past(wr_idx)]); // R5

endmodule

// File: rtl/ifu_ctrl.sv
module ifu_ctrl #(
    parameter int AW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [AW-1:0]             req_addr,
    input  logic                      req_cmode,
    output logic                      req_ready,
    input  logic                      cache_hit,
    input  logic [ifu_pkg::ILEN-1:0]  cache_data,
    output logic                      fill_en,
    output logic [AW-1:0]             fill_addr,
    output logic [ifu_pkg::ILEN-1:0]  fill_data,
    output logic                      mem_req,
    output logic [AW-1:0]             mem_addr,
    output logic                      mem_half,
    input  logic                      mem_ack,
    input  logic [ifu_pkg::ILEN-1:0]  mem_rdata,
    output logic                      inst_valid,
    output logic [ifu_pkg::ILEN-1:0]  inst_word
);
    import ifu_pkg::*;

    typedef struct packed {
        fetch_st_e       st;
        logic [AW-1:0]   addr;
        logic [HLEN-1:0] lo;
        logic            out_v;
        logic [ILEN-1:0] out_w;
    } regs_t;

    regs_t r_d, r_q;
    logic  crossing;

    assign crossing = req_cmode && (req_addr[1:0] == 2'b10);

    always_comb begin
        r_d       = r_q;
        r_d.out_v = 1'b0;
        fill_en   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    if (crossing) begin
                        r_d.st = ST_LO;
                    end else if (cache_hit) begin
                        r_d.out_v = 1'b1;
                        r_d.out_w = cache_data;
                    end else begin
                        r_d.st = ST_WORD;
                    end
                end
            end
            ST_WORD: begin
                if (mem_ack) begin
                    r_d.out_v = 1'b1;
                    r_d.out_w = mem_rdata;
                    fill_en   = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            ST_LO: begin
                if (mem_ack) begin
                    r_d.lo = mem_rdata[HLEN-1:0];
                    if (is_short(mem_rdata[HLEN-1:0])) begin
                        r_d.out_v = 1'b1;
                        r_d.out_w = {{(ILEN-HLEN){1'b0}}, mem_rdata[HLEN-1:0]};
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.st = ST_HI;
                    end
                end
            end
            ST_HI: begin
                if (mem_ack) begin
                    r_d.out_v = 1'b1;
                    r_d.out_w = {mem_rdata[HLEN-1:0], r_q.lo};
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, lo: '0, out_v: 1'b0, out_w: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign mem_req    = (r_q.st != ST_IDLE);
    assign mem_half   = (r_q.st == ST_LO) || (r_q.st == ST_HI);
    assign mem_addr   = (r_q.st == ST_HI) ? r_q.addr + AW'(2) : r_q.addr;
    assign fill_addr  = r_q.addr;
    assign fill_data  = mem_rdata;
    assign inst_valid = r_q.out_v;
    assign inst_word  = r_q.out_w;

    AST_CROSS_HALF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cmode && req_addr[1:0] == 2'b10)
        |=> (mem_req && mem_half && mem_addr == $past(req_addr))); // R1

    AST_SECOND_HALF_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_half && mem_ack && mem_addr[1:0] == 2'b10 && mem_rdata[1:0] == 2'b11)
        |=> (mem_req && mem_half && mem_addr == $past(mem_addr) + AW'(2))); // R2

    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_half && mem_ack && mem_addr[1:0] == 2'b10 && mem_rdata[1:0] != 2'b11)
        |=> (inst_valid && inst_word[ILEN-1:HLEN] == '0 && !mem_req)); // R3

    AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !crossing && cache_hit)
        |=> (inst_valid && !mem_req)); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_half))); // R9

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
    parameter int AW    = 32,
    parameter int IDX_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_cmode,
    output logic          req_ready,
    input  logic          flush,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_half,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          inst_valid,
    output logic [31:0]   inst_word
);
    logic          cache_hit;
    logic [31:0]   cache_data;
    logic          fill_en;
    logic [AW-1:0] fill_addr;
    logic [31:0]   fill_data;

    ifu_icache #(.AW(AW), .IDX_W(IDX_W)) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .rd_addr (req_addr),
        .rd_hit  (cache_hit),
        .rd_data (cache_data),
        .wr_en   (fill_en),
        .wr_addr (fill_addr),
        .wr_data (fill_data)
    );

    ifu_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_cmode  (req_cmode),
        .req_ready  (req_ready),
        .cache_hit  (cache_hit),
        .cache_data (cache_data),
        .fill_en    (fill_en),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_half   (mem_half),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .inst_valid (inst_valid),
        .inst_word  (inst_word)
    );

endmodule

// File: tb/ifetch_unit_test.sv
module ifetch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_cmode = 1'b0;
    logic        req_ready;
    logic        flush;
    logic        flush_man = 1'b0;
    logic        flush_auto = 1'b0;
    logic        flush_on_ack = 1'b0;
    logic        mem_req, mem_half;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        inst_valid;
    logic [31:0] inst_word;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int wait_n = 0;
    int log_n  = 0;
    logic [31:0] log_addr [4];
    logic        log_half [4];
    logic [31:0] first_addr;
    logic        first_half;

    assign flush = flush_man | flush_auto;

    always #5 clk = ~clk;

    ifetch_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmode(req_cmode), .req_ready(req_ready), .flush(flush),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_half(mem_half),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .inst_valid(inst_valid), .inst_word(inst_word)
    );

    // halfword image: low bits 11 (full width) when addr bit 4 is set, else 10
    function automatic logic [15:0] hw(input logic [31:0] a);
        return {a[15:5] ^ 11'h2B5, a[3:1], (a[4] ? 2'b11 : 2'b10)};
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a, input logic cm);
        logic [15:0] lo;
        if (cm && a[1:0] == 2'b10) begin
            lo = hw(a);
            if (lo[1:0] != 2'b11) return {16'h0000, lo};
            return {hw(a + 32'd2), lo};
        end
        return {hw(a + 32'd2), hw(a)};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory model, three cycles per access, driven away from the active edge
    always @(negedge clk) begin
        flush_auto = 1'b0;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req && rst_n) begin
            if (wait_n == 0) begin
                first_addr = mem_addr;
                first_half = mem_half;
            end
            wait_n++;
            if (wait_n == 3) begin
                check(mem_addr == first_addr && mem_half == first_half,
                      "R9 request held until ack", mem_addr, first_addr);
                if (log_n < 4) begin
                    log_addr[log_n] = mem_addr;
                    log_half[log_n] = mem_half;
                    log_n++;
                end
                mem_rdata = mem_half ? {16'h0000, hw(mem_addr)} : {hw(mem_addr + 32'd2), hw(mem_addr)};
                mem_ack   = 1'b1;
                wait_n    = 0;
                reads++;
                if (flush_on_ack) flush_auto = 1'b1;
            end
        end
    end

    task automatic fetch(input logic [31:0] a, input logic cm,
                         output logic [31:0] w, output int nr, output int lat);
        int r0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = reads;
        log_n = 0;
        req_valid = 1'b1;
        req_addr  = a;
        req_cmode = cm;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!inst_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        w  = inst_word;
        nr = reads - r0;
    endtask

    // {addr, cmode, expected memory reads}
    localparam logic [34:0] VECS [0:10] = '{
        {32'h0000_0100, 1'b0, 2'd1},  // R5 cold miss
        {32'h0000_0100, 1'b0, 2'd0},  // R4 hit
        {32'h0000_0500, 1'b0, 2'd1},  // R6 same index, other tag
        {32'h0000_0100, 1'b0, 2'd1},  // R6 evicted
        {32'h0000_0102, 1'b1, 2'd1},  // R3 short at boundary
        {32'h0000_0112, 1'b1, 2'd2},  // R2 full width across boundary
        {32'h0000_0100, 1'b1, 2'd0},  // R7 entry still hits
        {32'h0000_0102, 1'b0, 2'd1},  // R6 misaligned uses cache, tag differs
        {32'h0000_0102, 1'b0, 2'd0},  // R4 hit on misaligned tag
        {32'h0000_0102, 1'b1, 2'd1},  // R7 boundary path bypasses the hit
        {32'h0000_0100, 1'b0, 2'd1}   // R6 evicted by 0x102
    };

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w;
        int nr, lat;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'd1);
        check(mem_req == 1'b0, "R10 no memory request in reset", 32'(mem_req), 32'd0);
        check(inst_valid == 1'b0, "R10 no result in reset", 32'(inst_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 11; i++) begin
            logic [31:0] a;
            logic        cm;
            int          en;
            a  = VECS[i][34:3];
            cm = VECS[i][2];
            en = int'(VECS[i][1:0]);
            fetch(a, cm, w, nr, lat);
            check(w == exp_word(a, cm), $sformatf("R2/R3/R5 word vec %0d", i), w, exp_word(a, cm));
            check(nr == en, $sformatf("R4/R6/R7 reads vec %0d", i), 32'(nr), 32'(en));
            if (en == 0)
                check(lat == 1, $sformatf("R4 hit latency vec %0d", i), 32'(lat), 32'd1);
            if (cm && a[1:0] == 2'b10) begin
                check(log_half[0] && log_addr[0] == a, $sformatf("R1 first halfword vec %0d", i), log_addr[0], a);
                if (en == 2)
                    check(log_half[1] && log_addr[1] == a + 32'd2, "R2 second halfword address", log_addr[1], a + 32'd2);
            end else if (en != 0) begin
                check(!log_half[0] && log_addr[0] == a, $sformatf("R5 word read vec %0d", i), log_addr[0], a);
            end
        end

        // R10: a fresh address misses after reset
        fetch(32'h0000_0200, 1'b0, w, nr, lat);
        check(nr == 1, "R10 cache empty after reset", 32'(nr), 32'd1);
        fetch(32'h0000_0200, 1'b0, w, nr, lat);
        check(nr == 0, "R4 refetch hits", 32'(nr), 32'd0);

        // R8: flush between fetches
        @(negedge clk);
        flush_man = 1'b1;
        @(negedge clk);
        flush_man = 1'b0;
        fetch(32'h0000_0200, 1'b0, w, nr, lat);
        check(nr == 1, "R8 flushed entry misses", 32'(nr), 32'd1);
        check(w == exp_word(32'h200, 1'b0), "R8 word after flush", w, exp_word(32'h200, 1'b0));

        // R8: flush on the same edge as a fill wins
        flush_on_ack = 1'b1;
        fetch(32'h0000_0300, 1'b0, w, nr, lat);
        flush_on_ack = 1'b0;
        check(w == exp_word(32'h300, 1'b0), "R8 word delivered during flush", w, exp_word(32'h300, 1'b0));
        fetch(32'h0000_0300, 1'b0, w, nr, lat);
        check(nr == 1, "R8 fill dropped by flush", 32'(nr), 32'd1);
        fetch(32'h0000_0300, 1'b0, w, nr, lat);
        check(nr == 0, "R5 later fill kept", 32'(nr), 32'd0);

        // R3: short boundary word has upper half zero
        fetch(32'h0000_0422, 1'b1, w, nr, lat);
        check(w[31:16] == 16'h0000 && nr == 1, "R3 upper half zero", w, exp_word(32'h422, 1'b1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule